// File: doc/BRIEF.md
# Two-Wire Write Slave for a Quad Wiper Register Bank

This block receives write transfers from a two-wire (I2C-style) serial bus and uses them to update a register bank for four wiper channels. Each channel has one volatile wiper control register and four non-volatile data registers. SCL and SDA are oversampled on the system clock. The block finds START and STOP conditions and matches the address byte. It then decodes an instruction byte and applies one data byte to the register that the instruction selects. The block drives SDA only as an open-drain pull-down enable, and only during acknowledge bit times.

A write to a non-volatile data register is not applied at once. When the STOP arrives, an internal programming cycle of fixed length starts. The register takes the new value when that cycle ends. While the cycle runs, the slave refuses to acknowledge even its own address. A host can therefore poll for completion by sending START plus the address until an acknowledge comes back. An active-low write-protect input blocks non-volatile writes that have not started programming yet. It never blocks a cycle that is already running, and it never blocks wiper control writes. The non-volatile store is modelled as flops behind a cycle timer.

Top module: `dpot_tws_slave`

## Requirements
- R1: The address byte is eight bits, sent MSB first, and must equal the fixed nibble 0101 followed by `strap_i[3:0]`. A match is acknowledged by holding `sda_oe` high through the ninth clock. On a mismatch the slave gives no acknowledge and ignores every later byte until the next START.
- R2: The instruction byte carries the opcode in bits 7:4, the register select in bits 3:2 and the channel select in bits 1:0. Opcode 4'hA writes the wiper control register of that channel. Opcode 4'hC writes data register (channel*4 + register select) of the non-volatile bank. Every instruction byte is acknowledged.
- R3: A wiper control write stores data bits DW-1:0 (DW = 6) into the selected register at the data acknowledge, before STOP. It takes effect even when `wp_n_i` is low, and it never raises `busy_o`.
- R4: A data register write with `wp_n_i` high is acknowledged. The target register keeps its old value until the write completes. STOP raises `busy_o` for exactly PROG_CYCLES clocks, and the target register takes data bits DW-1:0 on the clock where `busy_o` falls.
- R5: While `busy_o` is high, the slave does not acknowledge its own address. Once `busy_o` is low, the same address byte is acknowledged again.
- R6: If `wp_n_i` is low when a data register write's data byte ends, the address and instruction bytes are still acknowledged but the data byte is not. No register changes and `busy_o` stays low.
- R7: If `wp_n_i` falls after the data acknowledge but before STOP, the STOP starts no programming cycle and no register changes.
- R8: A fall of `wp_n_i` after `busy_o` has risen has no effect: the cycle runs its full length and the register is updated.
- R9: A STOP that arrives before all eight data bits have been received ends the transfer with no register change and no busy cycle.
- R10: An instruction with an opcode other than 4'hA or 4'hC is acknowledged, and so is its data byte, but no register changes and `busy_o` stays low.
- R11: `sda_oe` changes only while the synchronized SCL is low, and it stays low during every bit the host sends.
- R12: After reset, all registers read zero and `busy_o` and `sda_oe` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data level on the bus |
| sda_oe | output | 1 | High pulls SDA low (acknowledge) |
| strap_i | input | 4 | Hard-wired low address bits |
| wp_n_i | input | 1 | Active-low write protect for data registers |
| busy_o | output | 1 | Programming cycle in progress |
| wcr_o | output | 4*DW | Wiper control registers, channel c at bits c*DW +: DW |
| nv_o | output | 16*DW | Data registers, slot (ch*4+reg) at bits slot*DW +: DW |

## Verification
A corrupted transfer state shows up first on `sda_oe` in the ninth clock of the byte where the decode goes wrong: an acknowledge is missing or appears where none belongs. A wrong wiper update is visible on `wcr_o` within a few system clocks of that acknowledge. A fault in the programming path shows only later, as a wrong `busy_o` window length or as a wrong `nv_o` value when the window closes. For that reason the bench measures every busy window and compares the whole register image against its own model after each transfer.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

  localparam logic [3:0] ADDR_FIXED = 4'b0101;
  localparam logic [3:0] OP_WCR     = 4'hA;
  localparam logic [3:0] OP_NVDR    = 4'hC;
  localparam int         NCH        = 4;
  localparam int         NREG       = 4;
  localparam int         NSLOT      = NCH * NREG;
  localparam int         SLOTW      = $clog2(NSLOT);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_INSTR, S_INSTR_ACK, S_DATA, S_DATA_ACK, S_IGNORE
  } xfer_state_t;

  typedef struct packed {
    logic [3:0] op;
    logic [1:0] sel_reg;
    logic [1:0] sel_ch;
  } instr_t;

  function automatic logic addr_hit(input logic [7:0] b, input logic [3:0] strap);
    return b == {ADDR_FIXED, strap};
  endfunction

  function automatic logic data_allowed(input logic [3:0] op, input logic wp_n);
    return !(op == OP_NVDR && !wp_n);
  endfunction

  function automatic logic [SLOTW-1:0] slot_of(input logic [1:0] ch, input logic [1:0] rs);
    return {ch, rs};
  endfunction

endpackage

// File: rtl/tws_bus_sync.sv
module tws_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_n_i,
  output logic scl_s,
  output logic sda_s,
  output logic wp_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_q, sda_q, wp_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      wp_q  <= '0;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      wp_q  <= {wp_q[STAGES-2:0], wp_n_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s    = scl_q[STAGES-1];
  assign sda_s    = sda_q[STAGES-1];
  assign wp_s     = wp_q[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/tws_xfer_fsm.sv
module tws_xfer_fsm
  import dpot_pkg::*;
#(
  parameter int DW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_s,
  input  logic             start_ev,
  input  logic             stop_ev,
  input  logic             wp_s,
  input  logic             busy,
  input  logic [3:0]       strap,
  output logic             sda_oe,
  output logic             addr_ack_ev,
  output logic             data_ack_ev,
  output logic [3:0]       cur_op,
  output logic             wcr_we,
  output logic [1:0]       wcr_ch,
  output logic             prog_req,
  output logic [SLOTW-1:0] prog_slot,
  output logic [DW-1:0]    wr_data
);
  xfer_state_t state;
  logic [7:0]  shreg;
  logic [3:0]  bitcnt;
  instr_t      instr_q;
  logic        pend;
  logic        byte_ok;
  logic        byte_done;

  assign byte_done = scl_fall && (bitcnt == 4'd8);

  always_comb begin
    case (state)
      S_ADDR:  byte_ok = addr_hit(shreg, strap) && !busy;
      S_INSTR: byte_ok = 1'b1;
      S_DATA:  byte_ok = data_allowed(instr_q.op, wp_s);
      default: byte_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      shreg       <= '0;
      bitcnt      <= '0;
      instr_q     <= '0;
      pend        <= 1'b0;
      sda_oe      <= 1'b0;
      addr_ack_ev <= 1'b0;
      data_ack_ev <= 1'b0;
      wcr_we      <= 1'b0;
      prog_req    <= 1'b0;
      wr_data     <= '0;
    end else begin
      addr_ack_ev <= 1'b0;
      data_ack_ev <= 1'b0;
      wcr_we      <= 1'b0;
      prog_req    <= 1'b0;
      if (stop_ev) begin
        state    <= S_IDLE;
        sda_oe   <= 1'b0;
        prog_req <= pend && wp_s && !busy;
        pend     <= 1'b0;
      end else if (start_ev) begin
        state  <= S_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
        pend   <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_INSTR, S_DATA: begin
            if (scl_rise && bitcnt != 4'd8) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_done) begin
              bitcnt <= '0;
              if (!byte_ok) begin
                state <= S_IGNORE;
              end else begin
                sda_oe <= 1'b1;
                case (state)
                  S_ADDR: begin
                    state       <= S_ADDR_ACK;
                    addr_ack_ev <= 1'b1;
                  end
                  S_INSTR: begin
                    state   <= S_INSTR_ACK;
                    instr_q <= instr_t'(shreg);
                  end
                  default: begin
                    state       <= S_DATA_ACK;
                    data_ack_ev <= 1'b1;
                    wr_data     <= shreg[DW-1:0];
                    wcr_we      <= (instr_q.op == OP_WCR);
                    pend        <= (instr_q.op == OP_NVDR);
                  end
                endcase
              end
            end
          end
          S_ADDR_ACK, S_INSTR_ACK, S_DATA_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              case (state)
                S_ADDR_ACK:  state <= S_INSTR;
                S_INSTR_ACK: state <= S_DATA;
                default:     state <= S_IGNORE;
              endcase
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign cur_op    = instr_q.op;
  assign wcr_ch    = instr_q.sel_ch;
  assign prog_slot = slot_of(instr_q.sel_ch, instr_q.sel_reg);
endmodule

// File: rtl/nv_prog_timer.sv
module nv_prog_timer #(
  parameter int CYCLES = 250000,
  parameter int DW     = 6,
  parameter int IDXW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [IDXW-1:0] idx,
  input  logic [DW-1:0]   data,
  output logic            busy,
  output logic            commit,
  output logic [IDXW-1:0] commit_idx,
  output logic [DW-1:0]   commit_data
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      cnt         <= '0;
      commit_idx  <= '0;
      commit_data <= '0;
    end else if (start && !busy) begin
      busy        <= 1'b1;
      cnt         <= LOAD;
      commit_idx  <= idx;
      commit_data <= data;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign commit = busy && (cnt == '0);
endmodule

// File: rtl/dpot_tws_slave.sv
module dpot_tws_slave
  import dpot_pkg::*;
#(
  parameter int DW          = 6,
  parameter int PROG_CYCLES = 250000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [3:0]        strap_i,
  input  logic              wp_n_i,
  output logic              busy_o,
  output logic [NCH*DW-1:0]   wcr_o,
  output logic [NSLOT*DW-1:0] nv_o
);
  logic scl_s, sda_s, wp_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic addr_ack_ev, data_ack_ev, wcr_we, prog_req, nv_commit;
  logic [3:0]       cur_op;
  logic [1:0]       wcr_ch;
  logic [SLOTW-1:0] prog_slot, commit_slot;
  logic [DW-1:0]    wr_data, commit_data;

  logic [DW-1:0] wcr_q [NCH];
  logic [DW-1:0] nv_q  [NSLOT];

  tws_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .wp_n_i(wp_n_i),
    .scl_s(scl_s), .sda_s(sda_s), .wp_s(wp_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  tws_xfer_fsm #(.DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_ev(start_ev), .stop_ev(stop_ev), .wp_s(wp_s),
    .busy(busy_o), .strap(strap_i), .sda_oe(sda_oe), .addr_ack_ev(addr_ack_ev),
    .data_ack_ev(data_ack_ev), .cur_op(cur_op), .wcr_we(wcr_we), .wcr_ch(wcr_ch),
    .prog_req(prog_req), .prog_slot(prog_slot), .wr_data(wr_data)
  );

  nv_prog_timer #(.CYCLES(PROG_CYCLES), .DW(DW), .IDXW(SLOTW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(prog_req), .idx(prog_slot), .data(wr_data),
    .busy(busy_o), .commit(nv_commit), .commit_idx(commit_slot),
    .commit_data(commit_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) wcr_q[i] <= '0;
    end else if (wcr_we) begin
      wcr_q[wcr_ch] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) nv_q[i] <= '0;
    end else if (nv_commit) begin
      nv_q[commit_slot] <= commit_data;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_wcr_out
    assign wcr_o[c*DW +: DW] = wcr_q[c];
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_nv_out
    assign nv_o[s*DW +: DW] = nv_q[s];
  end
endmodule

// File: rtl/dpot_tws_checker.sv
module dpot_tws_checker
  import dpot_pkg::*;
#(
  parameter int DW = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy_o,
  input logic                sda_oe,
  input logic                scl_s,
  input logic                wp_s,
  input logic                addr_ack_ev,
  input logic                data_ack_ev,
  input logic [3:0]          cur_op,
  input logic                prog_req,
  input logic                stop_ev,
  input logic                nv_commit,
  input logic                wcr_we,
  input logic [NCH*DW-1:0]   wcr_o,
  input logic [NSLOT*DW-1:0] nv_o
);
  // R5: no address acknowledge while programming
  p_no_addr_ack_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ack_ev |-> !busy_o);

  // R6: protected data register writes are never acknowledged
  p_wp_refuses_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ack_ev && cur_op == OP_NVDR) |-> wp_s);

  // R4: programming starts only from a STOP, and raises busy
  p_prog_from_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> $past(stop_ev));
  p_prog_sets_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> busy_o);

  // R4: data registers change only at the end of a cycle
  p_nv_only_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !nv_commit |=> $stable(nv_o));

  // R3: wiper registers change only on a wiper write
  p_wcr_only_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wcr_we |=> $stable(wcr_o));

  // R8: a running cycle is never cut short
  p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !nv_commit) |=> busy_o);

  // R11: the SDA pull-down moves only while SCL is low
  p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);
endmodule

bind dpot_tws_slave dpot_tws_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .sda_oe(sda_oe), .scl_s(scl_s),
  .wp_s(wp_s), .addr_ack_ev(addr_ack_ev), .data_ack_ev(data_ack_ev),
  .cur_op(cur_op), .prog_req(prog_req), .stop_ev(stop_ev), .nv_commit(nv_commit),
  .wcr_we(wcr_we), .wcr_o(wcr_o), .nv_o(nv_o)
);

// File: tb/test_dpot_tws_slave.sv
`timescale 1ns/1ps
module test_dpot_tws_slave;
  localparam int DW   = 6;
  localparam int PROG = 1200;
  localparam int Q    = 10;
  localparam logic [3:0] STRAP = 4'b0110;
  localparam logic [7:0] ADDR  = {4'b0101, STRAP};
  localparam logic [7:0] BADADDR = {4'b0101, STRAP ^ 4'b0001};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1, sda_drv = 1'b1, wp_n = 1'b1;
  logic sda_oe, busy_o;
  logic [4*DW-1:0]  wcr_o;
  logic [16*DW-1:0] nv_o;
  wire sda_line = sda_drv & ~sda_oe;

  always #10 clk = ~clk;

  dpot_tws_slave #(.DW(DW), .PROG_CYCLES(PROG)) i_dpot_tws_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_i(STRAP), .wp_n_i(wp_n), .busy_o(busy_o), .wcr_o(wcr_o), .nv_o(nv_o)
  );

  int n_cmp = 0, n_bad = 0, oe_bad = 0;
  int busy_run = 0, last_busy_len = 0;
  logic [DW-1:0] m_wcr [4];
  logic [DW-1:0] m_nv [16];
  bit    exp_ack_q[$];
  string exp_req_q[$];
  event  ack_slot;

  task automatic chk(input string req, input string what,
                     input logic [127:0] got, input logic [127:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [16*DW-1:0] pack_nv();
    logic [16*DW-1:0] v;
    for (int s = 0; s < 16; s++) v[s*DW +: DW] = m_nv[s];
    return v;
  endfunction

  function automatic logic [4*DW-1:0] pack_wcr();
    logic [4*DW-1:0] v;
    for (int c = 0; c < 4; c++) v[c*DW +: DW] = m_wcr[c];
    return v;
  endfunction

  task automatic check_bank(input string req);
    chk(req, "wcr_o", wcr_o, pack_wcr());
    chk(req, "nv_o", nv_o, pack_nv());
  endtask

  // scoreboard monitor: compares acknowledge slots against driver expectations
  initial forever begin
    @(ack_slot);
    if (exp_ack_q.size() == 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: ack slot with empty queue");
    end else begin
      bit e; string r;
      e = exp_ack_q.pop_front();
      r = exp_req_q.pop_front();
      chk(r, "ack", sda_oe, e);
    end
  end

  // busy window length monitor
  initial forever begin
    @(negedge clk);
    if (busy_o) busy_run++;
    else begin
      if (busy_run != 0) last_busy_len = busy_run;
      busy_run = 0;
    end
  end

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_drv = 1'b1; scl_drv = 1'b1; wait_q();
    sda_drv = 1'b0; wait_q();
    scl_drv = 1'b0; wait_q();
  endtask

  task automatic i2c_stop();
    sda_drv = 1'b0; wait_q();
    scl_drv = 1'b1; wait_q();
    sda_drv = 1'b1; wait_q(); wait_q();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_drv = b[i]; wait_q();
      scl_drv = 1'b1; wait_q();
      if (sda_oe !== 1'b0) oe_bad++;
      wait_q();
      scl_drv = 1'b0; wait_q();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    send_bits(b, 8);
    sda_drv = 1'b1;
    exp_ack_q.push_back(exp_ack);
    exp_req_q.push_back(req);
    wait_q();
    scl_drv = 1'b1; wait_q();
    -> ack_slot;
    wait_q();
    scl_drv = 1'b0; wait_q();
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) m_wcr[i] = '0;
    for (int i = 0; i < 16; i++) m_nv[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R12: reset state
    chk("R12", "busy_o", busy_o, 1'b0);
    chk("R12", "sda_oe", sda_oe, 1'b0);
    check_bank("R12");

    // R3: wiper write under write protect, visible before STOP
    wp_n = 1'b0;
    i2c_start();
    send_byte(ADDR, 1, "R1");
    send_byte({4'hA, 2'd3, 2'd2}, 1, "R2");
    send_byte(8'hAD, 1, "R3");
    m_wcr[2] = 6'h2D;
    check_bank("R3");
    i2c_stop();
    chk("R3", "busy_o", busy_o, 1'b0);
    // R3: upper data bits dropped
    i2c_start();
    send_byte(ADDR, 1, "R1");
    send_byte({4'hA, 2'd0, 2'd0}, 1, "R2");
    send_byte(8'hFF, 1, "R3");
    m_wcr[0] = 6'h3F;
    i2c_stop();
    check_bank("R3");
    wp_n = 1'b1;

    // R1: wrong address, rest ignored
    i2c_start();
    send_byte(BADADDR, 0, "R1");
    send_byte({4'hA, 2'd0, 2'd1}, 0, "R1");
    send_byte(8'h11, 0, "R1");
    i2c_stop();
    check_bank("R1");

    // R4/R5: data register write, busy window, polling
    i2c_start();
    send_byte(ADDR, 1, "R1");
    send_byte({4'hC, 2'd3, 2'd1}, 1, "R2");
    send_byte(8'h15, 1, "R4");
    i2c_stop();
    chk("R4", "busy_o", busy_o, 1'b1);
    check_bank("R4");
    i2c_start();
    send_byte(ADDR, 0, "R5");
    i2c_stop();
    chk("R5", "busy_o", busy_o, 1'b1);
    check_bank("R4");
    wait_idle();
    m_nv[1*4 + 3] = 6'h15;
    chk("R4", "busy_len", last_busy_len, PROG);
    check_bank("R4");
    i2c_start();
    send_byte(ADDR, 1, "R5");
    i2c_stop();

    // R2: field positions, channel 2 register 1
    i2c_start();
    send_byte(ADDR, 1, "R1");
    send_byte({4'hC, 2'd1, 2'd2}, 1, "R2");
    send_byte(8'h33, 1, "R2");
    i2c_stop();
    wait_idle();
    m_nv[2*4 + 1] = 6'h33;
    check_bank("R2");

    // R6: protected data byte refused
    wp_n = 1'b0;
    i2c_start();
    send_byte(ADDR, 1, "R6");
    send_byte({4'hC, 2'd0, 2'd0}, 1, "R6");
    send_byte(8'h3F, 0, "R6");
    i2c_stop();
    chk("R6", "busy_o", busy_o, 1'b0);
    check_bank("R6");
    wp_n = 1'b1;

    // R7: protect falls between data ack and STOP
    i2c_start();
    send_byte(ADDR, 1, "R7");
    send_byte({4'hC, 2'd2, 2'd0}, 1, "R7");
    send_byte(8'h2A, 1, "R7");
    wp_n = 1'b0;
    wait_q();
    i2c_stop();
    chk("R7", "busy_o", busy_o, 1'b0);
    check_bank("R7");
    wp_n = 1'b1;
    wait_q();

    // R8: protect falls during the cycle
    i2c_start();
    send_byte(ADDR, 1, "R1");
    send_byte({4'hC, 2'd2, 2'd3}, 1, "R8");
    send_byte(8'h0A, 1, "R8");
    i2c_stop();
    chk("R8", "busy_o", busy_o, 1'b1);
    wp_n = 1'b0;
    wait_idle();
    m_nv[3*4 + 2] = 6'h0A;
    chk("R8", "busy_len", last_busy_len, PROG);
    check_bank("R8");
    wp_n = 1'b1;
    wait_q();

    // R9: STOP inside the data byte
    i2c_start();
    send_byte(ADDR, 1, "R1");
    send_byte({4'hC, 2'd1, 2'd2}, 1, "R9");
    send_bits(8'h05, 4);
    i2c_stop();
    chk("R9", "busy_o", busy_o, 1'b0);
    check_bank("R9");

    // R10: unknown opcode
    i2c_start();
    send_byte(ADDR, 1, "R1");
    send_byte({4'h3, 2'd1, 2'd1}, 1, "R10");
    send_byte(8'h27, 1, "R10");
    i2c_stop();
    chk("R10", "busy_o", busy_o, 1'b0);
    check_bank("R10");

    // R11: no pull-down during host bits
    chk("R11", "oe_during_host_bits", oe_bad, 0);
    chk("R11", "queue_drained", exp_ack_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule